// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block with Term Steering

This block is one configurable logic cell of a larger programmable-logic fabric. It takes a set of external signals together with the registered state of its own sixteen macrocells as one literal bus. A programmable AND plane forms product terms over that bus. A term allocator then hands each product term to the macrocell that claims it, so a macrocell's OR gate may collect few or many terms rather than a fixed number.

Each macrocell ORs its terms, passes the sum through an XOR with a programmable polarity bit, and registers the result. A crossbar then lets every output pin pick any macrocell and choose either the combinational or the registered value of that macrocell.

All programming is held in internal registers that are written from the configuration ports in the cycle `cfg_load` is high. If a configuration lets two macrocells claim the same product term, the block drops that term and raises `cfg_err`.

Top module: `pal_block`

## Requirements
- R1: While `rst_n` is low and after its release, with no configuration loaded, every macrocell flip-flop holds 0, the stored configuration is all zeros, `io_out` is 0 and `cfg_err` is 0.
- R2: The literal bus is `{mc_q, ext_in}`, so bit i for i < 18 is `ext_in[i]` and bit 18+m is the flip-flop of macrocell m. Product term p is the AND of bit i for each i with `cfg_true[p*34+i]` set and of the inverse of bit i for each i with `cfg_comp[p*34+i]` set. A term with no literal selected evaluates to 1.
- R3: Macrocell m claims product term p when `cfg_own[p*16+m]` is 1. Its sum is the OR of all product terms it claims, and a macrocell that claims none has a sum of 0.
- R4: The combinational output of macrocell m is its sum XOR `cfg_pol[m]`.
- R5: On every rising clock edge out of reset, each macrocell flip-flop captures that macrocell's combinational output. That registered value is the one fed back on the literal bus.
- R6: Output pin o shows macrocell `cfg_osel[o*4 +: 4]`. It shows the flip-flop of that macrocell when `cfg_oreg[o]` is 1 and the combinational value when it is 0.
- R7: A product term claimed by two or more macrocells contributes to none of them. While such a configuration is stored, `cfg_err` is 1. Loading a configuration in which every term has at most one claimant returns `cfg_err` to 0.
- R8: Values on the configuration ports take effect only through a rising edge on which `cfg_load` is 1. Changes on those ports at any other time have no effect on `io_out` or `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | 18 | External literals, bits 0..17 of the literal bus |
| cfg_load | input | 1 | Store configuration ports on this edge |
| cfg_true | input | 1088 | Per term, per literal: include the true literal |
| cfg_comp | input | 1088 | Per term, per literal: include the inverted literal |
| cfg_own | input | 512 | Per term, per macrocell: macrocell claims the term |
| cfg_pol | input | 16 | Per macrocell output inversion |
| cfg_osel | input | 64 | Per pin 4-bit macrocell index |
| cfg_oreg | input | 16 | Per pin: 1 selects registered value, 0 combinational |
| io_out | output | 16 | Output pins |
| cfg_err | output | 1 | A stored term has more than one claimant |

## Verification
The assertions take for granted that `rst_n` is held low across at least one rising edge before any check starts. They also rely on `cfg_load` never being unknown, since the stored configuration and the error flag may only move after a load edge. The stimulus raises `cfg_load` for exactly one clock, drives every input on the falling edge, and changes configuration ports without a load only inside the scenario that checks they are ignored. The directed cases keep combinational paths free of loops because feedback is registered, so every expected value follows from the inputs and the known flip-flop phase.

// File: rtl/pal_pkg.sv
// Shared defaults for the sum-of-products logic block.
// Assumes: feedback literals are appended above the external literals.
package pal_pkg;
    localparam int PAL_N_EXT = 18;   // external literals
    localparam int PAL_N_MC  = 16;   // macrocells
    localparam int PAL_N_PT  = 32;   // product terms in the AND plane
    localparam int PAL_N_OUT = 16;   // output pins
endpackage

// File: rtl/pal_and_plane.sv
// AND plane: each product term is the AND of the literals its two masks pick.
// Assumes: a term with both masks clear for every literal evaluates to 1.
module pal_and_plane #(
    parameter int N_IN = 34,
    parameter int N_PT = 32
) (
    input  logic [N_IN-1:0]      lits,
    input  logic [N_PT*N_IN-1:0] use_true,
    input  logic [N_PT*N_IN-1:0] use_comp,
    output logic [N_PT-1:0]      term
);
    for (genvar p = 0; p < N_PT; p++) begin : g_term
        // one product term: every unused literal position passes a 1
        assign term[p] = &((~use_true[p*N_IN +: N_IN] |  lits) &
                           (~use_comp[p*N_IN +: N_IN] | ~lits));
    end
endmodule

// File: rtl/pal_term_alloc.sv
// Term allocator: steers each product term to the macrocell that claims it
// and forms the per-macrocell sums. A term with several claimants is dropped.
// Assumes: claim bits are indexed term-major, p*N_MC + m.
module pal_term_alloc #(
    parameter int N_MC = 16,
    parameter int N_PT = 32
) (
    input  logic [N_PT-1:0]      term,
    input  logic [N_PT*N_MC-1:0] own,
    output logic [N_MC-1:0]      sum,
    output logic                 conflict
);
    logic [N_PT-1:0] multi;

    for (genvar p = 0; p < N_PT; p++) begin : g_claim
        // term has more than one claimant
        assign multi[p] = ($countones(own[p*N_MC +: N_MC]) > 1);
    end

    assign conflict = |multi;

    // gather each macrocell's claimed, conflict-free terms into its OR gate
    always_comb begin
        sum = '0;
        for (int m = 0; m < N_MC; m++) begin
            for (int p = 0; p < N_PT; p++) begin
                sum[m] = sum[m] | (term[p] & own[p*N_MC + m] & ~multi[p]);
            end
        end
    end
endmodule

// File: rtl/pal_macrocell.sv
// Macrocell: polarity XOR on the OR sum, then a flip-flop.
// Assumes: synchronous active-low reset clears the flip-flop.
module pal_macrocell (
    input  logic clk,
    input  logic rst_n,
    input  logic sum,
    input  logic invert,
    output logic comb,
    output logic regd
);
    assign comb = sum ^ invert;

    // register the combinational result every edge
    always_ff @(posedge clk) begin
        if (!rst_n) regd <= 1'b0;
        else        regd <= comb;
    end
endmodule

// File: rtl/pal_out_switch.sv
// Output crossbar: every pin picks any macrocell, combinational or registered.
// Assumes: N_MC is a power of two so every select code names a macrocell.
module pal_out_switch #(
    parameter int N_MC  = 16,
    parameter int N_OUT = 16,
    parameter int SELW  = 4
) (
    input  logic [N_MC-1:0]       comb,
    input  logic [N_MC-1:0]       regd,
    input  logic [N_OUT*SELW-1:0] sel,
    input  logic [N_OUT-1:0]      use_reg,
    output logic [N_OUT-1:0]      pins
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_pin
        logic [SELW-1:0] idx;
        assign idx     = sel[o*SELW +: SELW];
        // pick the value source for this pin
        assign pins[o] = use_reg[o] ? regd[idx] : comb[idx];
    end
endmodule

// File: rtl/pal_block.sv
// Top of the logic block: stored configuration, AND plane, term allocator,
// macrocells and output crossbar. Feedback enters as literals N_EXT and up.
// Assumes: cfg_load is a clean synchronous strobe; feedback is registered,
// so no combinational loop can form inside the block.
module pal_block
    import pal_pkg::*;
#(
    parameter int N_EXT = PAL_N_EXT,
    parameter int N_MC  = PAL_N_MC,
    parameter int N_PT  = PAL_N_PT,
    parameter int N_OUT = PAL_N_OUT,
    localparam int N_IN = N_EXT + N_MC,
    localparam int SELW = $clog2(N_MC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_EXT-1:0]       ext_in,
    input  logic                   cfg_load,
    input  logic [N_PT*N_IN-1:0]   cfg_true,
    input  logic [N_PT*N_IN-1:0]   cfg_comp,
    input  logic [N_PT*N_MC-1:0]   cfg_own,
    input  logic [N_MC-1:0]        cfg_pol,
    input  logic [N_OUT*SELW-1:0]  cfg_osel,
    input  logic [N_OUT-1:0]       cfg_oreg,
    output logic [N_OUT-1:0]       io_out,
    output logic                   cfg_err
);
    logic [N_PT*N_IN-1:0]  act_true, act_comp;
    logic [N_PT*N_MC-1:0]  act_own;
    logic [N_MC-1:0]       act_pol;
    logic [N_OUT*SELW-1:0] act_osel;
    logic [N_OUT-1:0]      act_oreg;

    logic [N_PT-1:0] term;
    logic [N_MC-1:0] mc_sum, mc_comb, mc_q;
    logic            conflict;

    // hold the configuration; update only on a load edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_true <= '0;
            act_comp <= '0;
            act_own  <= '0;
            act_pol  <= '0;
            act_osel <= '0;
            act_oreg <= '0;
        end else if (cfg_load) begin
            act_true <= cfg_true;
            act_comp <= cfg_comp;
            act_own  <= cfg_own;
            act_pol  <= cfg_pol;
            act_osel <= cfg_osel;
            act_oreg <= cfg_oreg;
        end
    end

    pal_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .lits     ({mc_q, ext_in}),
        .use_true (act_true),
        .use_comp (act_comp),
        .term     (term)
    );

    pal_term_alloc #(.N_MC(N_MC), .N_PT(N_PT)) u_alloc (
        .term     (term),
        .own      (act_own),
        .sum      (mc_sum),
        .conflict (conflict)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        pal_macrocell u_mc (
            .clk    (clk),
            .rst_n  (rst_n),
            .sum    (mc_sum[m]),
            .invert (act_pol[m]),
            .comb   (mc_comb[m]),
            .regd   (mc_q[m])
        );
    end

    pal_out_switch #(.N_MC(N_MC), .N_OUT(N_OUT), .SELW(SELW)) u_osw (
        .comb    (mc_comb),
        .regd    (mc_q),
        .sel     (act_osel),
        .use_reg (act_oreg),
        .pins    (io_out)
    );

    assign cfg_err = conflict;
endmodule

// File: rtl/pal_block_chk.sv
// Checker for pal_block: timing of the error flag, configuration holding,
// register capture and the empty-claim case. Attached by bind below.
// Assumes: rst_n is held low over at least one rising edge at start.
module pal_block_chk #(
    parameter int N_MC = 16,
    parameter int N_PT = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_load,
    input logic                 cfg_err,
    input logic [N_MC-1:0]      mc_comb,
    input logic [N_MC-1:0]      mc_q,
    input logic [N_MC-1:0]      act_pol,
    input logic [N_PT*N_MC-1:0] act_own
);
    logic [N_MC-1:0] has_claim;

    // per macrocell: does any stored term name it
    always_comb begin
        has_claim = '0;
        for (int m = 0; m < N_MC; m++)
            for (int p = 0; p < N_PT; p++)
                has_claim[m] = has_claim[m] | act_own[p*N_MC + m];
    end

    AST_ERR_MOVES_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_load) |-> $stable(cfg_err)); // R7

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(act_pol) && $stable(act_own)); // R8

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> mc_q == $past(mc_comb)); // R5

    AST_NO_CLAIM_POL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((mc_comb ^ act_pol) & ~has_claim) == '0); // R3
endmodule

bind pal_block pal_block_chk #(.N_MC(N_MC), .N_PT(N_PT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_err  (cfg_err),
    .mc_comb  (mc_comb),
    .mc_q     (mc_q),
    .act_pol  (act_pol),
    .act_own  (act_own)
);

// File: tb/sim_pal_block.sv
`timescale 1ns/1ps
module sim_pal_block;
    localparam int N_EXT = 18;
    localparam int N_MC  = 16;
    localparam int N_PT  = 32;
    localparam int N_OUT = 16;
    localparam int N_IN  = N_EXT + N_MC;
    localparam int SELW  = 4;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [N_EXT-1:0]       ext_in;
    logic                   cfg_load;
    logic [N_PT*N_IN-1:0]   cfg_true, cfg_comp;
    logic [N_PT*N_MC-1:0]   cfg_own;
    logic [N_MC-1:0]        cfg_pol;
    logic [N_OUT*SELW-1:0]  cfg_osel;
    logic [N_OUT-1:0]       cfg_oreg;
    logic [N_OUT-1:0]       io_out;
    logic                   cfg_err;

    int n_checks = 0;
    int n_errors = 0;

    pal_block u0 (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .cfg_load(cfg_load),
        .cfg_true(cfg_true), .cfg_comp(cfg_comp), .cfg_own(cfg_own),
        .cfg_pol(cfg_pol), .cfg_osel(cfg_osel), .cfg_oreg(cfg_oreg),
        .io_out(io_out), .cfg_err(cfg_err)
    );

    always #2.5 clk = ~clk;

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_cfg();
        cfg_true = '0; cfg_comp = '0; cfg_own = '0;
        cfg_pol  = '0; cfg_osel = '0; cfg_oreg = '0;
    endtask

    task automatic set_pin(int o, int mc, logic regd);
        cfg_osel[o*SELW +: SELW] = SELW'(mc);
        cfg_oreg[o] = regd;
    endtask

    // one-cycle load strobe, returns after the stored config is visible
    task automatic load_cfg();
        @(negedge clk); cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_load = 1'b0; ext_in = '0; clear_cfg();
        repeat (3) @(negedge clk);
        #1;
        check("R1 io_out in reset", |io_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 io_out after reset", |io_out, 1'b0);
        check("R1 cfg_err after reset", cfg_err, 1'b0);
    endtask

    // mc0 = (e0 & ~e1) | e2 ; mc1 owns an empty term (constant 1)
    task automatic build_sop(logic inv0);
        clear_cfg();
        cfg_true[0*N_IN + 0] = 1'b1; cfg_comp[0*N_IN + 1] = 1'b1;
        cfg_own[0*N_MC + 0]  = 1'b1;
        cfg_true[1*N_IN + 2] = 1'b1;
        cfg_own[1*N_MC + 0]  = 1'b1;
        cfg_own[2*N_MC + 1]  = 1'b1;
        cfg_pol[0] = inv0;
        set_pin(0, 0, 1'b0);
        set_pin(1, 1, 1'b0);
    endtask

    task automatic t_sum_of_products();
        build_sop(1'b0);
        load_cfg();
        for (int v = 0; v < 8; v++) begin
            logic e;
            @(negedge clk); ext_in = '0; ext_in[2:0] = 3'(v); #1;
            e = (ext_in[0] & ~ext_in[1]) | ext_in[2];
            check("R2 R3 sum of products", io_out[0], e);
        end
        check("R2 empty term is 1", io_out[1], 1'b1);
    endtask

    task automatic t_polarity();
        build_sop(1'b1);
        load_cfg();
        for (int v = 0; v < 8; v += 3) begin
            logic e;
            @(negedge clk); ext_in = '0; ext_in[2:0] = 3'(v); #1;
            e = ~((ext_in[0] & ~ext_in[1]) | ext_in[2]);
            check("R4 inverted polarity", io_out[0], e);
        end
    endtask

    // mc2 = NOT of its own registered feedback (literal 18+2): toggles
    task automatic t_feedback();
        logic r;
        clear_cfg();
        cfg_comp[5*N_IN + N_EXT + 2] = 1'b1;
        cfg_own[5*N_MC + 2] = 1'b1;
        set_pin(2, 2, 1'b1);
        set_pin(3, 2, 1'b0);
        load_cfg();
        for (int k = 0; k < 4; k++) begin
            r = io_out[2];
            check("R5 comb is inverse of feedback", io_out[3], ~r);
            @(negedge clk); #1;
            check("R5 register toggles", io_out[2], ~r);
        end
    endtask

    task automatic t_crossbar();
        build_sop(1'b0);
        set_pin(5, 0, 1'b0);
        set_pin(15, 0, 1'b0);
        set_pin(9, 1, 1'b0);
        set_pin(10, 1, 1'b1);
        load_cfg();
        @(negedge clk); ext_in = '0; ext_in[2] = 1'b1; #1;
        check("R6 pin 5 from mc0", io_out[5], 1'b1);
        check("R6 pin 15 from mc0", io_out[15], 1'b1);
        @(negedge clk); ext_in = '0; #1;
        check("R6 pin 15 follows mc0 low", io_out[15], 1'b0);
        check("R6 pin 9 from mc1 comb", io_out[9], 1'b1);
        check("R6 pin 10 from mc1 reg", io_out[10], 1'b1);
        check("R6 unselected pin 4 on mc0", io_out[4], 1'b0);
    endtask

    task automatic t_conflict_and_ignore();
        clear_cfg();
        cfg_own[7*N_MC + 3] = 1'b1; cfg_own[7*N_MC + 4] = 1'b1;
        cfg_own[8*N_MC + 5] = 1'b1;
        set_pin(3, 3, 1'b0); set_pin(4, 4, 1'b0); set_pin(5, 5, 1'b0);
        load_cfg();
        check("R7 cfg_err on shared term", cfg_err, 1'b1);
        check("R7 mc3 loses shared term", io_out[3], 1'b0);
        check("R7 mc4 loses shared term", io_out[4], 1'b0);
        check("R7 other term kept", io_out[5], 1'b1);
        cfg_own[7*N_MC + 4] = 1'b0;
        load_cfg();
        check("R7 cfg_err cleared", cfg_err, 1'b0);
        check("R7 mc3 gets term", io_out[3], 1'b1);
        // change ports without a load: nothing may move
        cfg_pol[3] = 1'b1;
        cfg_own[7*N_MC + 4] = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R8 pol change ignored", io_out[3], 1'b1);
        check("R8 own change ignored", cfg_err, 1'b0);
        load_cfg();
        check("R8 applied after load err", cfg_err, 1'b1);
    endtask

    initial begin
        t_reset();
        t_sum_of_products();
        t_polarity();
        t_feedback();
        t_crossbar();
        t_conflict_and_ignore();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule